// File: doc/BRIEF.md
# Prescaled Local Timebase Counter

This block produces the 64-bit free-running count that per-core timers compare against. One of two tick-enable inputs is the input rate: a crystal-derived tick or an alternate bus-clock-derived tick. A 32-bit prescaler value is added into a fractional accumulator on each selected tick. Each time the accumulator reaches the half-scale weight (2^31), one increment is produced. The count then advances at the input tick rate times prescaler / 2^31.

Software configures the block through two write-only words that share one data bus: a control word and a prescaler word. Control bit 8 picks the tick source and control bit 9 picks a step of one or two per increment. With the reset settings (control 0, prescaler 0x80000000), the counter advances by one on every crystal tick. Every increment is also shown as a one-cycle strobe that is aligned with the count update.

Top module: `prescaled_timebase`

## Requirements
- R1: Reset gives count 0 and strobe 0, sets the control word so that the source is the crystal tick with step 1, and sets the prescaler to 0x80000000.
- R2: Control bit 8 = 0 selects `xtal_tick_i` and control bit 8 = 1 selects `alt_tick_i`. Ticks on the input that is not selected have no effect on the count.
- R3: Control bit 9 = 0 makes each increment add 1 to the count, and control bit 9 = 1 makes it add 2. The count never changes by any other amount.
- R4: After N selected ticks from reset, followed by enough idle cycles, the number of increments equals floor(N * prescaler / 2^31). No increment appears without a tick unless a remainder is still owed.
- R5: With prescaler 0x80000000, a selected tick sampled at a clock edge produces `inc_o` = 1 and the updated count right after that edge. `inc_o` returns to 0 on the next edge if there is no further tick.
- R6: `inc_o` is high for exactly one cycle per increment, and the count changes only in cycles where `inc_o` is high.
- R7: At most one increment occurs per clock cycle. When the prescaler exceeds 2^31, the excess is kept in the accumulator and paid out one increment per cycle in the following cycles, with or without ticks.
- R8: A prescaler write takes effect from the next selected tick. A tick in the same cycle as the write uses the old value, and the write does not clear the accumulator.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| xtal_tick_i | input | 1 | Crystal-derived tick enable |
| alt_tick_i | input | 1 | Alternate bus-clock-derived tick enable |
| ctrl_we_i | input | 1 | Write strobe for the control word (bit 8 source, bit 9 step) |
| pre_we_i | input | 1 | Write strobe for the prescaler word |
| wdata_i | input | 32 | Shared write data |
| count_o | output | 64 | Timebase count |
| inc_o | output | 1 | One-cycle strobe, high when the count advanced |

## Verification
A wrong source or step setting shows at the ports immediately: the count strobe on the cycle after a tick either appears when it should not or moves the count by the wrong amount. A corrupted accumulator cannot be seen on any single cycle. It shows only as a wrong total of increments over many ticks, or as missing or extra strobes in the idle cycles after a burst of ticks. For that reason each configuration is run for a burst and then left idle before the totals are compared.

// File: rtl/tbc_pkg.sv
package tbc_pkg;

    typedef enum logic {
        SRC_XTAL = 1'b0,
        SRC_ALT  = 1'b1
    } tb_src_e;

endpackage

// File: rtl/tbc_cfg_regs.sv
module tbc_cfg_regs
    import tbc_pkg::*;
#(
    parameter int unsigned PRE_W    = 32,
    parameter int unsigned SRC_BIT  = 8,
    parameter int unsigned STEP_BIT = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctrl_we,
    input  logic             pre_we,
    input  logic [PRE_W-1:0] wdata,
    output tb_src_e          src,
    output logic             step2,
    output logic [PRE_W-1:0] pre
);

    localparam logic [PRE_W-1:0] PRE_RST = {1'b1, {(PRE_W-1){1'b0}}};

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            src   <= SRC_XTAL;
            step2 <= 1'b0;
            pre   <= PRE_RST;
        end else begin
            if (ctrl_we) begin
                src   <= tb_src_e'(wdata[SRC_BIT]);
                step2 <= wdata[STEP_BIT];
            end
            if (pre_we) begin
                pre <= wdata;
            end
        end
    end

    // R8: a prescaler write is held from the next cycle on
    assert_pre_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
        pre_we |=> (pre == $past(wdata)));

endmodule

// File: rtl/tbc_frac_accum.sv
module tbc_frac_accum #(
    parameter int unsigned PRE_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic [PRE_W-1:0] pre,
    output logic             bump,
    output logic             owed
);

    localparam int unsigned ACC_W = PRE_W + 2;
    localparam logic [ACC_W:0] HALF    = (ACC_W+1)'(1) << (PRE_W - 1);
    localparam logic [ACC_W:0] ACC_MAX = {1'b0, {ACC_W{1'b1}}};

    logic [ACC_W-1:0] acc_q;
    logic [ACC_W-1:0] acc_d;
    logic [ACC_W:0]   sum;
    logic [ACC_W:0]   rem;

    always_comb begin
        sum  = {1'b0, acc_q} + (tick ? (ACC_W+1)'(pre) : '0);
        bump = (sum >= HALF);
        rem  = bump ? (sum - HALF) : sum;
        if (rem > ACC_MAX) begin
            rem = ACC_MAX;
        end
        acc_d = rem[ACC_W-1:0];
        owed  = ({1'b0, acc_q} >= HALF);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q <= '0;
        end else begin
            acc_q <= acc_d;
        end
    end

    // R4: with nothing owed and no tick, no increment is produced
    assert_no_free_bump_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !owed) |-> !bump);

endmodule

// File: rtl/tbc_count.sv
module tbc_count #(
    parameter int unsigned CNT_W = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bump,
    input  logic             step2,
    output logic [CNT_W-1:0] count,
    output logic             inc
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);
    localparam logic [CNT_W-1:0] TWO = CNT_W'(2);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
            inc   <= 1'b0;
        end else begin
            inc <= bump;
            if (bump) begin
                count <= count + (step2 ? TWO : ONE);
            end
        end
    end

    // R6: the count only moves alongside the strobe
    assert_move_with_strobe_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(count) |-> inc);

    // R3: each increment adds exactly one or two
    assert_step_size_R3: assert property (@(posedge clk) disable iff (!rst_n)
        inc |-> (((count - $past(count)) == ONE) || ((count - $past(count)) == TWO)));

endmodule

// File: rtl/prescaled_timebase.sv
module prescaled_timebase
    import tbc_pkg::*;
#(
    parameter int unsigned PRE_W    = 32,
    parameter int unsigned CNT_W    = 64,
    parameter int unsigned SRC_BIT  = 8,
    parameter int unsigned STEP_BIT = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             xtal_tick_i,
    input  logic             alt_tick_i,
    input  logic             ctrl_we_i,
    input  logic             pre_we_i,
    input  logic [PRE_W-1:0] wdata_i,
    output logic [CNT_W-1:0] count_o,
    output logic             inc_o
);

    tb_src_e          src;
    logic             step2;
    logic [PRE_W-1:0] pre;
    logic             sel_tick;
    logic             bump;
    logic             owed;

    tbc_cfg_regs #(
        .PRE_W   (PRE_W),
        .SRC_BIT (SRC_BIT),
        .STEP_BIT(STEP_BIT)
    ) u_cfg (
        .clk    (clk),
        .rst_n  (rst_n),
        .ctrl_we(ctrl_we_i),
        .pre_we (pre_we_i),
        .wdata  (wdata_i),
        .src    (src),
        .step2  (step2),
        .pre    (pre)
    );

    always_comb begin
        unique case (src)
            SRC_XTAL: sel_tick = xtal_tick_i;
            SRC_ALT:  sel_tick = alt_tick_i;
            default:  sel_tick = 1'b0;
        endcase
    end

    tbc_frac_accum #(
        .PRE_W(PRE_W)
    ) u_acc (
        .clk  (clk),
        .rst_n(rst_n),
        .tick (sel_tick),
        .pre  (pre),
        .bump (bump),
        .owed (owed)
    );

    tbc_count #(
        .CNT_W(CNT_W)
    ) u_cnt (
        .clk  (clk),
        .rst_n(rst_n),
        .bump (bump),
        .step2(step2),
        .count(count_o),
        .inc  (inc_o)
    );

    // R7: an owed remainder is paid out on the following strobe
    assert_owed_paid_R7: assert property (@(posedge clk) disable iff (!rst_n)
        owed |=> inc_o);

    // R4: idle and nothing owed means no strobe after the edge
    assert_idle_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!sel_tick && !owed) |=> !inc_o);

endmodule

// File: tb/sim_prescaled_timebase.sv
module sim_prescaled_timebase;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        xtal = 1'b0;
    logic        alt = 1'b0;
    logic        cwe = 1'b0;
    logic        pwe = 1'b0;
    logic [31:0] wd = '0;
    logic [63:0] count;
    logic        inc;

    int n_run = 0;
    int n_fail = 0;
    int pulses = 0;
    bit done = 0;

    always #10 clk = ~clk;

    prescaled_timebase u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .xtal_tick_i(xtal),
        .alt_tick_i (alt),
        .ctrl_we_i  (cwe),
        .pre_we_i   (pwe),
        .wdata_i    (wd),
        .count_o    (count),
        .inc_o      (inc)
    );

    // sel, step, prescaler, selected ticks, other-source ticks
    localparam logic [49:0] VEC [8] = '{
        {1'b0, 1'b0, 32'h8000_0000, 8'd10, 8'd20},
        {1'b1, 1'b0, 32'h8000_0000, 8'd7,  8'd15},
        {1'b0, 1'b1, 32'h8000_0000, 8'd5,  8'd9},
        {1'b0, 1'b0, 32'h4000_0000, 8'd9,  8'd12},
        {1'b1, 1'b1, 32'h2000_0000, 8'd16, 8'd16},
        {1'b0, 1'b0, 32'hC000_0000, 8'd8,  8'd8},
        {1'b0, 1'b0, 32'h0000_0000, 8'd10, 8'd10},
        {1'b0, 1'b0, 32'hFFFF_FFFF, 8'd4,  8'd6}
    };

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // inputs held across one rising edge; returns at the following falling edge
    task automatic cyc(input logic x, input logic a, input logic c, input logic p, input logic [31:0] d);
        xtal = x; alt = a; cwe = c; pwe = p; wd = d;
        @(negedge clk);
        if (inc) pulses++;
        xtal = 0; alt = 0; cwe = 0; pwe = 0; wd = '0;
    endtask

    task automatic do_reset();
        rst_n = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        pulses = 0;
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual 1 expected 0");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        // table walk: R2, R3, R4, R6
        for (int v = 0; v < 8; v++) begin
            logic        sel;
            logic        stp;
            logic [31:0] pr;
            int          ns;
            int          no;
            logic [63:0] exp_inc;
            {sel, stp, pr, ns, no} = {VEC[v][49], VEC[v][48], VEC[v][47:16],
                                      24'd0, VEC[v][15:8], 24'd0, VEC[v][7:0]};
            do_reset();
            cyc(0, 0, 1, 0, (32'(sel) << 8) | (32'(stp) << 9));
            cyc(0, 0, 0, 1, pr);
            for (int i = 0; i < no; i++) begin
                logic t;
                t = (i < ns);
                if (sel) cyc(1'b1, t, 0, 0, '0);
                else     cyc(t, 1'b1, 0, 0, '0);
            end
            repeat (40) cyc(0, 0, 0, 0, '0);
            exp_inc = (64'(ns) * 64'(pr)) >> 31;
            chk("R4/R2/R3 count", count, exp_inc * (stp ? 64'd2 : 64'd1));
            chk("R6 strobe total", 64'(pulses), exp_inc);
        end

        // R1: reset values
        do_reset();
        chk("R1 count", count, 64'd0);
        chk("R1 strobe", {63'd0, inc}, 64'd0);
        // R1 defaults: crystal source, step 1, 1:1; alternate ticks ignored
        cyc(0, 1, 0, 0, '0);
        chk("R1 alt ignored", count, 64'd0);
        repeat (3) cyc(1, 0, 0, 0, '0);
        chk("R1 default rate", count, 64'd3);

        // R5: strobe timing at 1:1
        do_reset();
        cyc(1, 0, 0, 0, '0);
        chk("R5 strobe high", {63'd0, inc}, 64'd1);
        chk("R5 count", count, 64'd1);
        cyc(0, 0, 0, 0, '0);
        chk("R5 strobe low", {63'd0, inc}, 64'd0);
        chk("R5 count held", count, 64'd1);

        // R7: prescaler above 2^31 clamps to one increment per cycle
        do_reset();
        cyc(0, 0, 0, 1, 32'hFFFF_FFFF);
        for (int k = 1; k <= 3; k++) begin
            cyc(1, 0, 0, 0, '0);
            chk("R7 one per cycle", count, 64'(k));
        end
        cyc(0, 0, 0, 0, '0);
        chk("R7 owed paid", count, 64'd4);

        // R8: write does not clear accumulator
        do_reset();
        cyc(0, 0, 0, 1, 32'h4000_0000);
        cyc(1, 0, 0, 0, '0);
        chk("R8 half tick", count, 64'd0);
        cyc(0, 0, 0, 1, 32'hC000_0000);
        cyc(1, 0, 0, 0, '0);
        chk("R8 carry kept", count, 64'd1);
        repeat (3) cyc(0, 0, 0, 0, '0);
        chk("R8 remainder", count, 64'd2);

        // R8: tick in the write cycle uses the old value
        do_reset();
        cyc(1, 0, 0, 1, 32'h0);
        chk("R8 old value", count, 64'd1);
        cyc(1, 0, 0, 0, '0);
        chk("R8 new value", count, 64'd1);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule